// File: doc/BRIEF.md
# Bidirectional DMA Transfer Sequencer

This block decides, one byte per clock, who moves data through a shared sector buffer. One side is a host DMA channel and the other is a disk DMA channel. The block does not hold the buffer. It keeps the buffer fill level, raises a write or read strobe toward the buffer storage for every byte moved, and counts the bytes each side has moved. It reports completion of the host request and of the disk request.

The block reacts only to events: a change of either direction bit, a rising DMA enable on either side, or a new host or disk request. On such an event it runs a short fixed sequence of steps. The host direction picks the order. When the host writes, the host fills the buffer first and the disk then drains it. When the host reads, the disk fills the buffer first, the host drains it, and the disk tops the buffer up again. Each step computes its byte quota when it starts and moves the bytes through a request/acknowledge handshake.

Top module: `dual_dma_sequencer`

## Requirements
- R1: With `host_write`=1, all bytes of the host step move before any disk byte. The disk then drains the buffer only if `disk_en`=1 and `disk_read`=0.
- R2: With `host_write`=0, the disk fills the buffer first (needs `disk_en`=1 and `disk_read`=1). The host drains it next. The disk then refills the buffer while its request is still open. Each phase is a run of bytes from one side only.
- R3: A host step moves min(host bytes remaining, buffer level) when it reads, and min(host bytes remaining, free space) when it writes. Free space is CAP minus the level, where CAP = BUF_SECTORS*SECTOR_BYTES.
- R4: A disk step moves min(disk bytes remaining, level or free space). The disk bytes remaining are `disk_sectors`*SECTOR_BYTES minus the bytes already moved, so a disk request never moves more than that product.
- R5: When the disk has moved all `disk_sectors`*SECTOR_BYTES bytes, `disk_moved` returns to 0, `disk_ready` falls, and `disk_done` is high for exactly one cycle.
- R6: When `host_moved` reaches the requested length, `host_busy` falls, `host_moved` holds the length, and `host_done` is high for exactly one cycle.
- R7: A host length above CAP is clipped to CAP.
- R8: Bytes move only in a sequence started by an event. A side whose enable is low at the start of its step moves nothing in that step.
- R9: A step with a quota of zero is skipped, and the sequence goes on to its next step.
- R10: Every byte moved raises exactly one of `buf_wr` or `buf_rd`. `buf_level` rises by one on each `buf_wr` and falls by one on each `buf_rd`, and stays within 0 to CAP.
- R11: A byte moves only in a cycle where a request and its acknowledge are both high. An unanswered request stays high, and at most one side requests at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_write | input | 1 | 1: host writes into the buffer; 0: host reads from it |
| host_en | input | 1 | Host DMA enable |
| host_start | input | 1 | One-cycle pulse that loads a new host request |
| host_len | input | HLEN_W | Host request length in bytes |
| disk_read | input | 1 | 1: disk fills the buffer; 0: disk drains it |
| disk_en | input | 1 | Disk DMA enable |
| disk_start | input | 1 | One-cycle pulse that loads a new disk request |
| disk_sectors | input | SEC_W | Disk request length in sectors |
| host_ack | input | 1 | Host side accepts or supplies the requested byte |
| disk_ack | input | 1 | Disk side accepts or supplies the requested byte |
| host_req | output | 1 | Host byte request |
| disk_req | output | 1 | Disk byte request |
| buf_wr | output | 1 | One byte is written into the buffer |
| buf_rd | output | 1 | One byte is read out of the buffer |
| buf_level | output | LVL_W | Bytes held in the buffer |
| host_moved | output | HLEN_W | Host bytes moved in the current request |
| disk_moved | output | SEC_W+log2(SECTOR_BYTES) | Disk bytes moved in the current request |
| host_busy | output | 1 | Host request open |
| disk_ready | output | 1 | Disk request open |
| host_done | output | 1 | One-cycle host completion pulse |
| disk_done | output | 1 | One-cycle disk completion pulse |

## Verification
The hardest case to reach is the three-phase read sequence where all three steps move bytes: disk fill, then host drain, then disk refill. This needs a buffer that is partly full, a disk request larger than the free space, and a host request large enough to leave room for the refill. The bench builds this with earlier directed steps that leave a known level behind. It then loads both requests in the same cycle, so that one event produces the whole sequence. A sweep over host lengths and sector counts in both directions, with irregular acknowledge patterns, then compares the final counts against figures computed from the quota rules.

// File: rtl/dds_pkg.sv
package dds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOST_IN,
      ST_DISK_OUT,
      ST_DISK_FILL,
      ST_HOST_OUT,
      ST_DISK_REFILL
   } dds_state_e;

endpackage

// File: rtl/dds_event_detect.sv
module dds_event_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic host_write,
   input  logic disk_read,
   input  logic host_en,
   input  logic disk_en,
   input  logic host_start,
   input  logic disk_start,
   output logic eval
);
   logic prev_hw, prev_dr, prev_he, prev_de;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_hw <= 1'b0;
         prev_dr <= 1'b0;
         prev_he <= 1'b0;
         prev_de <= 1'b0;
      end else begin
         prev_hw <= host_write;
         prev_dr <= disk_read;
         prev_he <= host_en;
         prev_de <= disk_en;
      end
   end

   assign eval = host_start | disk_start
               | (host_write ^ prev_hw) | (disk_read ^ prev_dr)
               | (host_en & ~prev_he) | (disk_en & ~prev_de);
endmodule

// File: rtl/dds_side_track.sv
module dds_side_track #(
   parameter int CW            = 8,
   parameter bit CLEAR_ON_DONE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] total,
   input  logic          byte_ok,
   output logic          active,
   output logic [CW-1:0] moved,
   output logic [CW-1:0] remaining,
   output logic          done
);
   logic [CW-1:0] tot_q;
   logic [CW-1:0] moved_nxt;
   logic [CW-1:0] moved_final;

   assign moved_nxt = moved + 1'b1;

   generate
      if (CLEAR_ON_DONE) begin : g_clear
         assign moved_final = '0;
      end else begin : g_hold
         assign moved_final = moved_nxt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_q  <= '0;
         moved  <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else if (load) begin
         tot_q  <= total;
         moved  <= '0;
         active <= (total != '0);
         done   <= (total == '0);
      end else if (byte_ok && active) begin
         if (moved_nxt == tot_q) begin
            moved  <= moved_final;
            active <= 1'b0;
            done   <= 1'b1;
         end else begin
            moved  <= moved_nxt;
            done   <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assign remaining = active ? (tot_q - moved) : '0;
endmodule

// File: rtl/dds_step_fsm.sv
module dds_step_fsm
   import dds_pkg::*;
#(
   parameter int CAP   = 16,
   parameter int LVL_W = 5,
   parameter int HW    = 6,
   parameter int DW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eval,
   input  logic             host_write,
   input  logic             disk_read,
   input  logic             host_en,
   input  logic             disk_en,
   input  logic             host_active,
   input  logic             disk_active,
   input  logic [HW-1:0]    host_rem,
   input  logic [DW-1:0]    disk_rem,
   input  logic             host_ack,
   input  logic             disk_ack,
   output logic             host_req,
   output logic             disk_req,
   output logic             host_byte,
   output logic             disk_byte,
   output logic             buf_wr,
   output logic             buf_rd,
   output logic [LVL_W-1:0] level
);
   localparam int RW0 = (HW > DW) ? HW : DW;
   localparam int RW  = (RW0 > LVL_W) ? RW0 : LVL_W;

   dds_state_e       state, nxt_step;
   logic             armed, pending;
   logic [LVL_W-1:0] left;
   logic             ok;
   logic [RW-1:0]    room, rem, quota_w;
   logic [LVL_W-1:0] quota, space;
   logic             host_step, disk_step, side_active, moved_any;

   assign space     = LVL_W'(CAP) - level;
   assign host_step = (state == ST_HOST_IN) || (state == ST_HOST_OUT);
   assign disk_step = (state == ST_DISK_OUT) || (state == ST_DISK_FILL)
                   || (state == ST_DISK_REFILL);

   always_comb begin
      ok       = 1'b0;
      room     = '0;
      rem      = '0;
      nxt_step = ST_IDLE;
      unique case (state)
         ST_HOST_IN: begin
            ok = host_active && host_en;
            room = RW'(space); rem = RW'(host_rem); nxt_step = ST_DISK_OUT;
         end
         ST_DISK_OUT: begin
            ok = disk_active && disk_en && !disk_read;
            room = RW'(level); rem = RW'(disk_rem); nxt_step = ST_IDLE;
         end
         ST_DISK_FILL: begin
            ok = disk_active && disk_en && disk_read;
            room = RW'(space); rem = RW'(disk_rem); nxt_step = ST_HOST_OUT;
         end
         ST_HOST_OUT: begin
            ok = host_active && host_en;
            room = RW'(level); rem = RW'(host_rem); nxt_step = ST_DISK_REFILL;
         end
         ST_DISK_REFILL: begin
            ok = disk_active && disk_en && disk_read;
            room = RW'(space); rem = RW'(disk_rem); nxt_step = ST_IDLE;
         end
         default: begin
            ok = 1'b0;
         end
      endcase
   end

   assign quota_w     = (rem < room) ? rem : room;
   assign quota       = ok ? quota_w[LVL_W-1:0] : '0;
   assign side_active = host_step ? host_active : disk_active;
   assign host_req    = armed && host_step && host_active;
   assign disk_req    = armed && disk_step && disk_active;
   assign host_byte   = host_req && host_ack;
   assign disk_byte   = disk_req && disk_ack;
   assign moved_any   = host_byte || disk_byte;
   assign buf_wr      = ((state == ST_HOST_IN) && host_byte)
                     || (((state == ST_DISK_FILL) || (state == ST_DISK_REFILL)) && disk_byte);
   assign buf_rd      = ((state == ST_HOST_OUT) && host_byte)
                     || ((state == ST_DISK_OUT) && disk_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         armed   <= 1'b0;
         pending <= 1'b0;
         left    <= '0;
      end else if (state == ST_IDLE) begin
         armed <= 1'b0;
         if (eval || pending) begin
            pending <= 1'b0;
            state   <= host_write ? ST_HOST_IN : ST_DISK_FILL;
         end
      end else begin
         if (eval) pending <= 1'b1;
         if (!armed) begin
            if (quota == '0) begin
               state <= nxt_step;
            end else begin
               armed <= 1'b1;
               left  <= quota;
            end
         end else if (!side_active) begin
            armed <= 1'b0;
            state <= nxt_step;
         end else if (moved_any) begin
            left <= left - 1'b1;
            if (left == LVL_W'(1)) begin
               armed <= 1'b0;
               state <= nxt_step;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      level <= '0;
      else if (buf_wr) level <= level + 1'b1;
      else if (buf_rd) level <= level - 1'b1;
   end
endmodule

// File: rtl/dual_dma_sequencer.sv
module dual_dma_sequencer #(
   parameter int SECTOR_BYTES = 512,
   parameter int BUF_SECTORS  = 16,
   parameter int SEC_W        = 8,
   parameter int HLEN_W       = 14,
   localparam int CAP   = SECTOR_BYTES * BUF_SECTORS,
   localparam int LVL_W = $clog2(CAP + 1),
   localparam int SB_LOG = $clog2(SECTOR_BYTES),
   localparam int DW    = SEC_W + SB_LOG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_write,
   input  logic              host_en,
   input  logic              host_start,
   input  logic [HLEN_W-1:0] host_len,
   input  logic              disk_read,
   input  logic              disk_en,
   input  logic              disk_start,
   input  logic [SEC_W-1:0]  disk_sectors,
   input  logic              host_ack,
   input  logic              disk_ack,
   output logic              host_req,
   output logic              disk_req,
   output logic              buf_wr,
   output logic              buf_rd,
   output logic [LVL_W-1:0]  buf_level,
   output logic [HLEN_W-1:0] host_moved,
   output logic [DW-1:0]     disk_moved,
   output logic              host_busy,
   output logic              disk_ready,
   output logic              host_done,
   output logic              disk_done
);
   generate
      if ((SECTOR_BYTES < 2) || ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0)) begin : g_bad_sector
         $error("SECTOR_BYTES must be a power of two of at least 2");
      end
      if (CAP >= (1 << HLEN_W)) begin : g_bad_hlen
         $error("HLEN_W too narrow for the buffer capacity");
      end
   endgenerate

   logic              eval;
   logic [HLEN_W-1:0] host_total, host_rem;
   logic [DW-1:0]     disk_total, disk_rem;
   logic              host_byte, disk_byte;

   assign host_total = (host_len > HLEN_W'(CAP)) ? HLEN_W'(CAP) : host_len;
   assign disk_total = {disk_sectors, {SB_LOG{1'b0}}};

   dds_event_detect u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_write (host_write),
      .disk_read  (disk_read),
      .host_en    (host_en),
      .disk_en    (disk_en),
      .host_start (host_start),
      .disk_start (disk_start),
      .eval       (eval)
   );

   dds_side_track #(.CW(HLEN_W), .CLEAR_ON_DONE(1'b0)) u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (host_start),
      .total     (host_total),
      .byte_ok   (host_byte),
      .active    (host_busy),
      .moved     (host_moved),
      .remaining (host_rem),
      .done      (host_done)
   );

   dds_side_track #(.CW(DW), .CLEAR_ON_DONE(1'b1)) u_disk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (disk_start),
      .total     (disk_total),
      .byte_ok   (disk_byte),
      .active    (disk_ready),
      .moved     (disk_moved),
      .remaining (disk_rem),
      .done      (disk_done)
   );

   dds_step_fsm #(.CAP(CAP), .LVL_W(LVL_W), .HW(HLEN_W), .DW(DW)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .eval        (eval),
      .host_write  (host_write),
      .disk_read   (disk_read),
      .host_en     (host_en),
      .disk_en     (disk_en),
      .host_active (host_busy),
      .disk_active (disk_ready),
      .host_rem    (host_rem),
      .disk_rem    (disk_rem),
      .host_ack    (host_ack),
      .disk_ack    (disk_ack),
      .host_req    (host_req),
      .disk_req    (disk_req),
      .host_byte   (host_byte),
      .disk_byte   (disk_byte),
      .buf_wr      (buf_wr),
      .buf_rd      (buf_rd),
      .level       (buf_level)
   );
endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
   parameter int CAP   = 16,
   parameter int LVL_W = 5,
   parameter int DW    = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             buf_wr,
   input logic             buf_rd,
   input logic [LVL_W-1:0] buf_level,
   input logic             host_req,
   input logic             host_ack,
   input logic             host_start,
   input logic             disk_req,
   input logic             host_busy,
   input logic             host_done,
   input logic             disk_ready,
   input logic             disk_done,
   input logic [DW-1:0]    disk_moved
);
   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_wr && buf_rd));
   a_r10_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
      buf_level <= LVL_W'(CAP));
   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd |-> buf_level != '0);
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |-> buf_level != LVL_W'(CAP));
   a_r10_level_up: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr |=> buf_level == $past(buf_level) + 1'b1);
   a_r11_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_req && disk_req));
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      host_req && !host_ack && !host_start |=> host_req);
   a_r4_disk_req_open: assert property (@(posedge clk) disable iff (!rst_n)
      disk_req |-> disk_ready);
   a_r5_disk_done: assert property (@(posedge clk) disable iff (!rst_n)
      disk_done |-> (!disk_ready && disk_moved == '0));
   a_r6_host_done: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |-> !host_busy);
endmodule

bind dual_dma_sequencer dds_checker #(.CAP(CAP), .LVL_W(LVL_W), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .buf_wr     (buf_wr),
   .buf_rd     (buf_rd),
   .buf_level  (buf_level),
   .host_req   (host_req),
   .host_ack   (host_ack),
   .host_start (host_start),
   .disk_req   (disk_req),
   .host_busy  (host_busy),
   .host_done  (host_done),
   .disk_ready (disk_ready),
   .disk_done  (disk_done),
   .disk_moved (disk_moved)
);

// File: tb/dual_dma_sequencer_test.sv
module dual_dma_sequencer_test;
   localparam int SB  = 4;
   localparam int BS  = 4;
   localparam int SW  = 4;
   localparam int HW  = 6;
   localparam int CAP = SB * BS;
   localparam int LW  = $clog2(CAP + 1);
   localparam int DW  = SW + $clog2(SB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_write = 1'b0, host_en = 1'b0, host_start = 1'b0;
   logic [HW-1:0] host_len = '0;
   logic disk_read = 1'b0, disk_en = 1'b0, disk_start = 1'b0;
   logic [SW-1:0] disk_sectors = '0;
   logic host_ack = 1'b0, disk_ack = 1'b0;
   logic host_req, disk_req, buf_wr, buf_rd;
   logic [LW-1:0] buf_level;
   logic [HW-1:0] host_moved;
   logic [DW-1:0] disk_moved;
   logic host_busy, disk_ready, host_done, disk_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit host_hold = 1'b0;
   int tick = 0;
   int hb = 0, db = 0, hdone_n = 0, ddone_n = 0;
   int nph = 0;
   int ph_side [8];
   int ph_len  [8];

   always #4 clk = ~clk;

   dual_dma_sequencer #(.SECTOR_BYTES(SB), .BUF_SECTORS(BS), .SEC_W(SW), .HLEN_W(HW)) uut (
      .clk(clk), .rst_n(rst_n), .host_write(host_write), .host_en(host_en),
      .host_start(host_start), .host_len(host_len), .disk_read(disk_read),
      .disk_en(disk_en), .disk_start(disk_start), .disk_sectors(disk_sectors),
      .host_ack(host_ack), .disk_ack(disk_ack), .host_req(host_req),
      .disk_req(disk_req), .buf_wr(buf_wr), .buf_rd(buf_rd), .buf_level(buf_level),
      .host_moved(host_moved), .disk_moved(disk_moved), .host_busy(host_busy),
      .disk_ready(disk_ready), .host_done(host_done), .disk_done(disk_done)
   );

   always @(negedge clk) begin
      tick++;
      host_ack = ((tick % 3) != 2) && !host_hold;
      disk_ack = (tick % 5) != 3;
   end

   task automatic note(input int side);
      if (nph == 0 || (nph <= 8 && ph_side[nph-1] != side)) begin
         if (nph < 8) begin
            ph_side[nph] = side;
            ph_len[nph]  = 1;
         end
         nph++;
      end else if (nph <= 8) begin
         ph_len[nph-1]++;
      end
   endtask

   always @(posedge clk) begin
      if (rst_n) begin
         if (host_req && host_ack) begin hb++; note(0); end
         if (disk_req && disk_ack) begin db++; note(1); end
         if (host_done) hdone_n++;
         if (disk_done) ddone_n++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      hb = 0; db = 0; hdone_n = 0; ddone_n = 0; nph = 0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start(input bit h, input int len, input bit d, input int sec);
      @(negedge clk);
      host_start = h; host_len = HW'(len);
      disk_start = d; disk_sectors = SW'(sec);
      @(negedge clk);
      host_start = 1'b0; disk_start = 1'b0;
   endtask

   function automatic int mn(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int lev;
      settle(3);
      rst_n = 1'b1;
      settle(2);
      // reset state (R10, R11)
      chk("R10 reset level", int'(buf_level), 0);
      chk("R11 reset host_req", int'(host_req), 0);
      chk("R11 reset disk_req", int'(disk_req), 0);
      chk("R6 reset host_busy", int'(host_busy), 0);
      chk("R5 reset disk_ready", int'(disk_ready), 0);

      // R1: write order, host 12 then disk 8
      host_write = 1'b1; host_en = 1'b1; disk_en = 1'b1; disk_read = 1'b0;
      settle(20);
      clear_mon();
      start(1'b1, 12, 1'b1, 2);
      settle(150);
      chk("R1 phases", nph, 2);
      chk("R1 first side host", ph_side[0], 0);
      chk("R1 host phase len", ph_len[0], 12);
      chk("R1 disk phase len", ph_len[1], 8);
      chk("R10 level", int'(buf_level), 4);
      chk("R5 disk_moved cleared", int'(disk_moved), 0);
      chk("R5 disk_ready low", int'(disk_ready), 0);
      chk("R5 disk_done pulses", ddone_n, 1);
      chk("R6 host_done pulses", hdone_n, 1);
      chk("R6 host_moved holds", int'(host_moved), 12);

      // R3: host write limited by free space
      clear_mon();
      start(1'b1, 16, 1'b0, 0);
      settle(150);
      chk("R3 host moved by space", int'(host_moved), 12);
      chk("R3 host still busy", int'(host_busy), 1);
      chk("R10 level full", int'(buf_level), 16);

      // R9: host step quota zero skipped, disk drains
      clear_mon();
      start(1'b0, 0, 1'b1, 3);
      settle(150);
      chk("R9 host bytes in skipped step", hb, 0);
      chk("R9 disk drained", db, 12);
      chk("R9 level", int'(buf_level), 4);

      // R6: host_en re-trigger finishes host request
      clear_mon();
      @(negedge clk); host_en = 1'b0;
      @(negedge clk); host_en = 1'b1;
      settle(150);
      chk("R6 host_moved", int'(host_moved), 16);
      chk("R6 host_busy", int'(host_busy), 0);
      chk("R6 host_done pulses", hdone_n, 1);
      chk("R10 level", int'(buf_level), 8);

      // R8: direction changes with nothing open move nothing
      clear_mon();
      @(negedge clk); host_write = 1'b0;
      settle(20);
      @(negedge clk); disk_read = 1'b1;
      settle(20);
      chk("R8 no bytes", hb + db, 0);
      chk("R8 level kept", int'(buf_level), 8);

      // R4: disk fill limited by space
      clear_mon();
      start(1'b0, 0, 1'b1, 3);
      settle(150);
      chk("R4 disk fill", int'(disk_moved), 8);
      chk("R4 disk ready", int'(disk_ready), 1);
      chk("R10 level", int'(buf_level), 16);

      // R7: host length clipped to capacity
      clear_mon();
      start(1'b1, 40, 1'b0, 0);
      settle(150);
      chk("R7 host moved clipped", int'(host_moved), 16);
      chk("R7 host done", hdone_n, 1);
      chk("R2 refill after drain", db, 4);
      chk("R10 level", int'(buf_level), 4);

      // R2: three-phase read sequence
      clear_mon();
      start(1'b1, 14, 1'b1, 4);
      settle(200);
      chk("R2 phases", nph, 3);
      chk("R2 phase0 disk", ph_side[0], 1);
      chk("R2 phase0 len", ph_len[0], 12);
      chk("R2 phase1 host", ph_side[1], 0);
      chk("R2 phase1 len", ph_len[1], 14);
      chk("R2 phase2 disk", ph_side[2], 1);
      chk("R2 phase2 len", ph_len[2], 4);
      chk("R10 level", int'(buf_level), 6);

      // R8: disabled host moves nothing until enable rises
      clear_mon();
      @(negedge clk); host_en = 1'b0;
      start(1'b1, 5, 1'b0, 0);
      settle(50);
      chk("R8 disabled host no bytes", hb, 0);
      chk("R8 disabled host busy", int'(host_busy), 1);
      @(negedge clk); host_en = 1'b1;
      settle(100);
      chk("R8 enabled host moved", int'(host_moved), 5);
      chk("R10 level", int'(buf_level), 1);

      // R11: unanswered request held
      clear_mon();
      @(negedge clk); host_write = 1'b1;
      settle(20);
      host_hold = 1'b1;
      start(1'b1, 3, 1'b0, 0);
      settle(10);
      chk("R11 req held", int'(host_req), 1);
      chk("R11 nothing moved", int'(host_moved), 0);
      host_hold = 1'b0;
      settle(50);
      chk("R11 moved after ack", int'(host_moved), 3);
      chk("R10 level", int'(buf_level), 4);

      // sweep, host write direction (R3, R4, R5, R6)
      start(1'b1, 0, 1'b1, 0);
      @(negedge clk); disk_read = 1'b0;
      settle(20);
      for (int i = 0; i < 16; i++) begin
         int L, S, D, h, d;
         lev = int'(buf_level);
         L = i + 1; S = ((i + 2) % 4) + 1; D = S * SB;
         h = mn(L, CAP - lev); lev += h;
         d = mn(D, lev); lev -= d;
         clear_mon();
         start(1'b1, L, 1'b1, S);
         settle(150);
         chk("R3 sweep-w host_moved", int'(host_moved), h);
         chk("R6 sweep-w host_busy", int'(host_busy), (h < L) ? 1 : 0);
         chk("R6 sweep-w host_done", hdone_n, (h == L) ? 1 : 0);
         chk("R4 sweep-w disk_moved", int'(disk_moved), (d == D) ? 0 : d);
         chk("R5 sweep-w disk_ready", int'(disk_ready), (d < D) ? 1 : 0);
         chk("R5 sweep-w disk_done", ddone_n, (d == D) ? 1 : 0);
         chk("R10 sweep-w level", int'(buf_level), lev);
      end

      // sweep, host read direction (R2, R3, R4)
      start(1'b1, 0, 1'b1, 0);
      @(negedge clk); host_write = 1'b0; disk_read = 1'b1;
      settle(20);
      for (int i = 0; i < 16; i++) begin
         int L, S, D, f1, h, f2;
         lev = int'(buf_level);
         L = i + 1; S = (i % 4) + 1; D = S * SB;
         f1 = mn(D, CAP - lev); lev += f1;
         h = mn(L, lev); lev -= h;
         f2 = mn(D - f1, CAP - lev); lev += f2;
         clear_mon();
         start(1'b1, L, 1'b1, S);
         settle(200);
         chk("R3 sweep-r host_moved", int'(host_moved), h);
         chk("R6 sweep-r host_done", hdone_n, (h == L) ? 1 : 0);
         chk("R2 sweep-r disk bytes", db, f1 + f2);
         chk("R4 sweep-r disk_moved", int'(disk_moved), (f1 + f2 == D) ? 0 : f1 + f2);
         chk("R5 sweep-r disk_ready", int'(disk_ready), (f1 + f2 < D) ? 1 : 0);
         chk("R10 sweep-r level", int'(buf_level), lev);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule